// File: doc/BRIEF.md
# Dual-Clock FIFO With Status Flags

This block is an 18-bit first-in first-out buffer whose write side and read side each run on their own free-running clock. The two clocks may be the same net or unrelated. A word is stored on each write-clock rising edge while the write enable is high and the buffer is not full. A word is taken on each read-clock rising edge while the read enable is high and the buffer is not empty. The taken word appears on a registered read-data output.

Pointers cross between the domains as Gray code through two-stage synchronizers. Each domain computes its own occupancy and registers its own flags. The read side owns Empty and Almost Empty. The write side owns Half Full, Almost Full and Full. The almost thresholds come from two offset inputs that are held static in normal use.

A retransmit pulse on the read side rewinds the read pointer to the first location written after reset, so the stored words can be replayed. An output-enable input qualifies the read data. While it is low, the data output reads as zero.

Top module: `dcf_top`

## Requirements
- R1: When `wr_en` is 1 and `full` is 0 at a `wr_clk` rising edge, `wr_data` is stored. When `rd_en` is 1, `empty` is 0 and `rt` is 0 at a `rd_clk` rising edge, the oldest unread word is loaded into the read register just after that edge. The register holds its value on every other edge.
- R2: A write attempted while `full` is 1 is dropped. A read attempted while `empty` is 1 is dropped. Neither pointer moves, and the read register keeps its value.
- R3: While `rst_n` is 0 (asynchronous, active low), both pointers and the read register are cleared. `empty` and `almost_empty` read 1, and `full`, `half_full` and `almost_full` read 0.
- R4: `empty` is registered on `rd_clk` only. It is 1 when the read-side occupancy is 0. With the two clocks tied, `empty` after edge n is 1 exactly when the writes accepted up to edge n-3 equal the read pointer after edge n.
- R5: `full` is registered on `wr_clk` only. It is 1 when the write-side occupancy equals DEPTH. With the two clocks tied, the write side sees the read pointer from three edges earlier.
- R6: `half_full` is registered on `wr_clk`. It is 1 when the write-side occupancy is greater than DEPTH/2.
- R7: `almost_full` is registered on `wr_clk`. It is 1 when the write-side occupancy is at least DEPTH minus `af_gap`.
- R8: `almost_empty` is registered on `rd_clk`. It is 1 when the read-side occupancy is at most `ae_gap`. It is therefore always 1 while `empty` is 1.
- R9: When `rt` is 1 at a `rd_clk` edge, the read pointer is set to location 0 and no read takes place on that edge, even if `rd_en` is 1. The following reads replay from the first word written after reset. This is valid only while no more than DEPTH words have been written since reset.
- R10: While `oe` is 0, `rd_data` is all zeros. While `oe` is 1, `rd_data` shows the read register. `oe` does not affect whether reads are accepted.
- R11: With independent clocks and simultaneous traffic, every accepted word is read out once and in order. After traffic stops, `empty` and `almost_empty` settle to 1, and `full` and `half_full` settle to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W (18) | Word to store |
| rd_en | input | 1 | Read request |
| rt | input | 1 | Retransmit: rewind the read pointer to location 0 |
| oe | input | 1 | Output enable; when low, read data is forced to zero |
| ae_gap | input | AW (6) | Almost-empty threshold |
| af_gap | input | AW (6) | Almost-full distance from DEPTH |
| rd_data | output | DATA_W (18) | Read register, qualified by `oe` |
| empty | output | 1 | No words visible to the read side |
| almost_empty | output | 1 | Read-side occupancy at most `ae_gap` |
| half_full | output | 1 | Write-side occupancy above DEPTH/2 |
| almost_full | output | 1 | Write-side occupancy at least DEPTH minus `af_gap` |
| full | output | 1 | Write-side occupancy equals DEPTH |

## Verification
The bench drives the design with tied clocks and compares all five flags and the data output against a model on every clock, including the three-edge delay through the synchronizers. A design whose synchronizer is one stage short or long would show `empty` falling a cycle early or late. The bench pushes writes past Full and reads past Empty. A pointer that moved on an ignored request would skip or repeat a word. It also pulses retransmit together with a read request. If the read were not suppressed on that edge, word 0 would be lost, and if the rewind were wrong, the replay would start at the wrong word. Finally, it runs the read side on an unrelated clock, where a broken Gray crossing would corrupt the word order or leave a stale flag after the traffic stops.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  // Number of flops in each pointer synchronizer
  localparam int SYNC_STAGES = 2;
  // Default word width of the buffer
  localparam int WORD_W = 18;
endpackage

// File: rtl/dcf_sync.sv
// Carries a Gray-coded pointer into another clock domain and returns it as binary.
module dcf_sync #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] stage [dcf_pkg::SYNC_STAGES];
  logic [PW-1:0] g;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < dcf_pkg::SYNC_STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= gray_in;
      for (int i = 1; i < dcf_pkg::SYNC_STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign g = stage[dcf_pkg::SYNC_STAGES-1];

  always_comb begin
    bin_out[PW-1] = g[PW-1];
    for (int i = PW-2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ g[i];
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
// Write-side pointer and the flags owned by the write clock.
module dcf_wr_ctl #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int PW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] af_gap,
  input  logic [PW-1:0] rptr_seen,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          wr_fire,
  output logic          full,
  output logic          half_full,
  output logic          almost_full
);
  logic [PW-1:0] wptr, wptr_nx, fill_nx;

  function automatic logic [PW-1:0] span(input logic [PW-1:0] head, input logic [PW-1:0] tail);
    return head - tail;
  endfunction

  assign wr_fire = wr_en & ~full;
  assign wptr_nx = wptr + PW'(wr_fire);
  assign fill_nx = span(wptr_nx, rptr_seen);
  assign waddr   = wptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr        <= '0;
      wgray       <= '0;
      full        <= 1'b0;
      half_full   <= 1'b0;
      almost_full <= 1'b0;
    end else begin
      wptr        <= wptr_nx;
      wgray       <= wptr_nx ^ (wptr_nx >> 1);
      full        <= (fill_nx == PW'(DEPTH));
      half_full   <= (fill_nx > PW'(DEPTH / 2));
      almost_full <= (fill_nx >= PW'(DEPTH) - PW'(af_gap));
    end
  end

  // R2: a write attempted while full leaves the pointer in place
  a_r2_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en) |=> (wptr == $past(wptr)));
  // R5: the write side never counts more than DEPTH words
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    span(wptr, rptr_seen) <= PW'(DEPTH));
  // R6, R7: full implies the weaker write-side flags
  a_r7_full_implies_almost: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (almost_full && half_full));
endmodule

// File: rtl/dcf_rd_ctl.sv
// Read-side pointer, retransmit rewind and the flags owned by the read clock.
module dcf_rd_ctl #(
  parameter int AW = 6,
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          rt,
  input  logic [AW-1:0] ae_gap,
  input  logic [PW-1:0] wptr_seen,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          rd_fire,
  output logic          empty,
  output logic          almost_empty
);
  logic [PW-1:0] rptr, rptr_nx, fill_nx;

  function automatic logic [PW-1:0] span(input logic [PW-1:0] head, input logic [PW-1:0] tail);
    return head - tail;
  endfunction

  assign rd_fire = rd_en & ~empty & ~rt;
  assign rptr_nx = rt ? '0 : rptr + PW'(rd_fire);
  assign fill_nx = span(wptr_seen, rptr_nx);
  assign raddr   = rptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr         <= '0;
      rgray        <= '0;
      empty        <= 1'b1;
      almost_empty <= 1'b1;
    end else begin
      rptr         <= rptr_nx;
      rgray        <= rptr_nx ^ (rptr_nx >> 1);
      empty        <= (fill_nx == '0);
      almost_empty <= (fill_nx <= PW'(ae_gap));
    end
  end

  // R2: a read attempted while empty leaves the pointer in place
  a_r2_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !rt) |=> (rptr == $past(rptr)));
  // R9: retransmit puts the read pointer back at location 0
  a_r9_rewind_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rt |=> (rptr == '0));
  // R8: empty always reads as almost empty too
  a_r8_empty_implies_almost: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> almost_empty);
endmodule

// File: rtl/dcf_ram.sv
// Storage array with a write port and a registered read port.
module dcf_ram #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 64,
  parameter int AW     = 6
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/dcf_top.sv
// Dual-clock FIFO with Empty, Almost Empty, Half Full, Almost Full and Full flags.
module dcf_top #(
  parameter  int DATA_W = dcf_pkg::WORD_W,
  parameter  int DEPTH  = 64,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rt,
  input  logic              oe,
  input  logic [AW-1:0]     ae_gap,
  input  logic [AW-1:0]     af_gap,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              almost_empty,
  output logic              half_full,
  output logic              almost_full,
  output logic              full
);
  localparam int PW = AW + 1;

  logic [AW-1:0]     waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wptr_seen, rptr_seen;
  logic              wr_fire, rd_fire;
  logic [DATA_W-1:0] q;

  dcf_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .af_gap(af_gap),
    .rptr_seen(rptr_seen), .waddr(waddr), .wgray(wgray), .wr_fire(wr_fire),
    .full(full), .half_full(half_full), .almost_full(almost_full));

  dcf_rd_ctl #(.AW(AW), .PW(PW)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .rt(rt), .ae_gap(ae_gap),
    .wptr_seen(wptr_seen), .raddr(raddr), .rgray(rgray), .rd_fire(rd_fire),
    .empty(empty), .almost_empty(almost_empty));

  dcf_sync #(.PW(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wptr_seen));

  dcf_sync #(.PW(PW)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rptr_seen));

  dcf_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .wclk(wr_clk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .rst_n(rst_n), .re(rd_fire), .raddr(raddr), .q(q));

  assign rd_data = oe ? q : '0;

  // R10: with the output disabled, the data pins read as zero
  a_r10_oe_blanks: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !oe |-> (rd_data == '0));
endmodule

// File: tb/tb_dcf_top.sv
module tb_dcf_top;
  localparam int D  = 64;
  localparam int AW = 6;
  localparam int M2 = 2 * D;

  logic clk = 0, clk2 = 0, split = 0;
  logic rd_clk;
  logic rst_n = 0;
  logic wr_en = 0, rd_en = 0, rt = 0, oe = 1;
  logic [17:0] wr_data = '0;
  logic [AW-1:0] ae_gap = 6'd4, af_gap = 6'd5;
  logic [17:0] rd_data;
  logic empty, almost_empty, half_full, almost_full, full;

  always #10 clk = ~clk;
  always #7  clk2 = ~clk2;
  assign rd_clk = split ? clk2 : clk;

  dcf_top dut (
    .wr_clk(clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rt(rt), .oe(oe), .ae_gap(ae_gap), .af_gap(af_gap),
    .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty),
    .half_full(half_full), .almost_full(almost_full), .full(full));

  int checks = 0, errors = 0, seq = 0;
  bit done = 0;

  // behavioural model state
  logic [17:0] mem_m [D];
  int mW, mR;
  int wh [4];
  int rh [4];
  logic [17:0] m_q;
  bit m_empty, m_ae, m_full, m_hf, m_af;

  function automatic int md(int x);
    return ((x % M2) + M2) % M2;
  endfunction

  function automatic logic [17:0] word_of(int n);
    return 18'((n * 7919 + 677) & 18'h3FFFF);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    mW = 0; mR = 0; m_q = '0;
    for (int i = 0; i < 4; i++) begin wh[i] = 0; rh[i] = 0; end
    m_empty = 1; m_ae = 1; m_full = 0; m_hf = 0; m_af = 0;
  endtask

  task automatic do_reset(bit sp);
    rst_n = 0; wr_en = 0; rd_en = 0; rt = 0; oe = 1;
    split = sp;
    repeat (3) @(negedge clk);
    model_reset();
    // R3: reset state
    chk(empty == 1, "R3 empty", empty, 1);
    chk(almost_empty == 1, "R3 almost_empty", almost_empty, 1);
    chk(full == 0, "R3 full", full, 0);
    chk(half_full == 0, "R3 half_full", half_full, 0);
    chk(almost_full == 0, "R3 almost_full", almost_full, 0);
    chk(rd_data == 0, "R3 rd_data", rd_data, 0);
    rst_n = 1;
  endtask

  task automatic model_edge(bit w, bit r, bit t, logic [17:0] d);
    bit wacc, racc;
    int rcnt, wcnt;
    wacc = w && !m_full;
    racc = r && !m_empty && !t;
    if (wacc) begin mem_m[mW % D] = d; mW = md(mW + 1); end
    if (t) mR = 0;
    else if (racc) begin m_q = mem_m[mR % D]; mR = md(mR + 1); end
    for (int i = 3; i > 0; i--) begin wh[i] = wh[i-1]; rh[i] = rh[i-1]; end
    wh[0] = mW; rh[0] = mR;
    rcnt = md(wh[3] - mR);
    wcnt = md(mW - rh[3]);
    m_empty = (rcnt == 0);
    m_ae    = (rcnt <= int'(ae_gap));
    m_full  = (wcnt == D);
    m_hf    = (wcnt > D / 2);
    m_af    = (wcnt >= D - int'(af_gap));
  endtask

  task automatic step(bit w, bit r, bit t, bit o);
    logic [17:0] d;
    d = word_of(seq); seq++;
    wr_en = w; rd_en = r; rt = t; oe = o; wr_data = d;
    @(negedge clk);
    model_edge(w, r, t, d);
    chk(empty == m_empty, "R4 empty", empty, m_empty);
    chk(full == m_full, "R5 full", full, m_full);
    chk(half_full == m_hf, "R6 half_full", half_full, m_hf);
    chk(almost_full == m_af, "R7 almost_full", almost_full, m_af);
    chk(almost_empty == m_ae, "R8 almost_empty", almost_empty, m_ae);
    // R1, R2, R9, R10: data register and output qualification
    chk(rd_data == (o ? m_q : 18'd0), "R1/R2/R9/R10 rd_data", rd_data, o ? m_q : 18'd0);
  endtask

  // phase with independent clocks
  logic [17:0] q2 [$];

  task automatic split_writer();
    int pushed = 0;
    while (pushed < 50) begin
      if (!full) begin
        wr_data = word_of(1000 + pushed);
        q2.push_back(wr_data);
        wr_en = 1;
        pushed++;
      end else wr_en = 0;
      @(negedge clk);
    end
    wr_en = 0;
  endtask

  task automatic split_reader();
    int got = 0, k = 0;
    bit pend = 0;
    while (got < 50) begin
      @(negedge clk2);
      if (pend) begin
        if (q2.size() > 0) begin
          logic [17:0] e;
          e = q2.pop_front();
          chk(rd_data == e, "R11 order", rd_data, e);
        end else chk(0, "R11 underrun", rd_data, 0);
        got++;
      end
      k++;
      pend = !empty && (k % 3 != 0);
      rd_en = pend;
    end
    rd_en = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset(0);
    repeat (10) step(1, 0, 0, 1);   // R1 fill part way
    repeat (4)  step(0, 0, 0, 1);
    repeat (5)  step(0, 1, 0, 1);   // R1 reads
    step(0, 1, 1, 1);               // R9 retransmit with read request
    repeat (12) step(0, 1, 0, 1);   // R9 replay, then R2 read past empty
    repeat (20) step(1, 1, 0, 1);   // simultaneous traffic
    repeat (4)  step(0, 0, 0, 1);
    repeat (25) step(0, 1, 0, 1);   // R2 drain and over-read
    repeat (70) step(1, 0, 0, 1);   // R2 write past full, R5/R6/R7
    repeat (3)  step(0, 0, 0, 1);
    ae_gap = 6'd0; af_gap = 6'd0;
    repeat (10) step(0, 1, 0, 0);   // R10 reads with output disabled
    repeat (60) step(0, 1, 0, 1);   // R8 with new gap
    repeat (5)  step(0, 0, 0, 1);

    ae_gap = 6'd4; af_gap = 6'd5;
    do_reset(1);
    fork
      split_writer();
      split_reader();
    join
    repeat (10) @(negedge clk);
    chk(empty == 1, "R11 empty settles", empty, 1);
    chk(almost_empty == 1, "R11 almost_empty settles", almost_empty, 1);
    chk(full == 0, "R11 full settles", full, 0);
    chk(half_full == 0, "R11 half_full settles", half_full, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule